// File: doc/BRIEF.md
# Cascaded Up/Down Timer with Write-Collision Arbitration

This block joins two 16-bit counters into one 32-bit count: the low counter steps on an enable input, in a direction chosen by a direction input, and every wrap of the low counter steps the high counter once in the same direction. Around the pair sit a low compare register, a high compare register, a high general register that can capture on a compare event, four event-capture registers that latch the high count on every low-counter wrap, and a buffered capture pair on the low side. A capture strobe loads the low count into the capture register and moves the old capture value into the buffer register.

Software writes registers through a two-phase port. In the address phase it raises `bus_t1` with `bus_addr`. In the following data phase it drives `bus_wdata`. The write lands at the clock edge that closes the data phase. A combinational read port returns any register by address. The block defines a fixed outcome whenever a data-phase write falls in the same cycle as a hardware event. These rules let software and hardware share the registers without lost or torn updates.

Register addresses: 0 low count, 1 high count, 2 low compare, 3 high compare, 4 high general register, 5 low capture, 6 low buffer, 7 control, 8 to 11 event-capture registers 0 to 3. Unmapped addresses read as zero and ignore writes. Control bits: bit 0 enables clear on compare, bit 1 makes the high general register capture on a match event, and bits 5:2 enable event-capture registers 0 to 3.

Top module: `casc_timer`

## Requirements
- R1: A write issued with `bus_t1` high in cycle N takes `bus_wdata` from cycle N+1. Absent a collision, `rd_data` shows the written value from cycle N+2 onward. Writes to unmapped addresses 12 to 15 change nothing, and those addresses read as zero.
- R2: While `cnt_en` is high the low count steps by one at each clock: up when `cnt_dn` is 0, down when it is 1. `lo_carry` is high, for that cycle only, when the count is about to go from 0xFFFF to 0x0000 counting up, or from 0x0000 to 0xFFFF counting down.
- R3: Each `lo_carry` cycle that is not suppressed steps the high count by one in the direction given by `cnt_dn`.
- R4: A `cap_in` pulse copies the low count into the low capture register. In the same edge it moves the previous capture value into the low buffer register.
- R5: A data-phase write to the low buffer or low capture register in a `cap_in` cycle is discarded, and the capture transfer of R4 takes place.
- R6: A data-phase write to the low count in a `lo_carry` cycle is applied to the low count. The step of the high count is suppressed, so the high count holds its value.
- R7: `up_match` is high in any `lo_carry` cycle, suppressed or not, in which the high count equals the high compare register.
- R8: Each enabled event-capture register loads the high count in every `lo_carry` cycle, suppressed or not. In that cycle the capture wins over a write to that register.
- R9: With control bit 1 set, the high general register loads the high count in every `up_match` cycle. In that cycle the capture wins over a write to that register.
- R10: With control bit 0 set, `cnt_clear` is high while the low count equals the low compare register and the high count equals the high compare register. Both counts are zero in the next cycle, and neither counts or carries in that cycle.
- R11: After reset every register reads zero.
- R12: A data-phase write to a count has priority over a step and over a clear of that count. This includes a write to the high count in a `lo_carry` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_t1 | input | 1 | Address phase of a register write |
| bus_addr | input | 4 | Write address, sampled with `bus_t1` |
| bus_wdata | input | 16 | Write data, sampled in the data phase |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| cnt_en | input | 1 | Low counter step enable |
| cnt_dn | input | 1 | Count direction, 1 = down |
| cap_in | input | 1 | Buffered capture strobe for the low side |
| lo_carry | output | 1 | Low counter wrap in this cycle |
| up_match | output | 1 | High compare match event |
| cnt_clear | output | 1 | Both counters clear at the next edge |

## Verification
`lo_carry`, `up_match` and `cnt_clear` are combinational from the registers and the present inputs. They are compared against a bench model in the same cycle, shortly after the inputs settle. Register effects land at the edge that ends the cycle of the cause: the edge after the data phase for writes, and the edge of the wrap, capture or clear cycle for hardware events. A random register is read through the combinational port one cycle later, before the next edge. Directed sequences place a data phase exactly on the wrap cycle or on the capture cycle, then read the affected registers immediately after that edge.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int N_CAP0 = 4;

  localparam logic [3:0] A_LCNT    = 4'd0;
  localparam logic [3:0] A_UCNT    = 4'd1;
  localparam logic [3:0] A_LCMP    = 4'd2;
  localparam logic [3:0] A_UCMPA   = 4'd3;
  localparam logic [3:0] A_UREGB   = 4'd4;
  localparam logic [3:0] A_LCAP    = 4'd5;
  localparam logic [3:0] A_LBUF    = 4'd6;
  localparam logic [3:0] A_CTRL    = 4'd7;
  localparam int         A_C0_BASE = 8;

  typedef struct packed {
    logic [N_CAP0-1:0] cap0_en;
    logic              capb_match;
    logic              clr_en;
  } ctl_t;

  localparam int CTLW = $bits(ctl_t);
endpackage

// File: rtl/ctm_wport.sv
module ctm_wport #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t1,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          t2_q, t2_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    t2_d   = t1;
    addr_d = addr_q;
    if (t1) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      t2_q   <= t2_d;
      addr_q <= addr_d;
    end
  end

  assign wr_en   = t2_q;
  assign wr_addr = addr_q;
  assign wr_data = wdata_in;

  a_r1_data_phase_follows: assert property (@(posedge clk) disable iff (!rst_n)
    t1 |=> (wr_en && wr_addr == $past(addr_in)));
endmodule

// File: rtl/ctm_lower.sv
module ctm_lower #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_dn,
  input  logic         clr,
  input  logic         cap_in,
  input  logic         wr_cnt,
  input  logic         wr_cap,
  input  logic         wr_buf,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap,
  output logic [W-1:0] bfr,
  output logic         carry
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d, bfr_q, bfr_d;
  logic         at_top, at_bot;

  assign at_top = &cnt_q;
  assign at_bot = ~|cnt_q;
  assign carry  = cnt_en && !clr && (cnt_dn ? at_bot : at_top);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)      cnt_d = wr_data;
    else if (clr)    cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_dn ? cnt_q - ONE : cnt_q + ONE;
  end

  always_comb begin
    cap_d = cap_q;
    bfr_d = bfr_q;
    if (cap_in) begin
      cap_d = cnt_q;
      bfr_d = cap_q;
    end else begin
      if (wr_cap) cap_d = wr_data;
      if (wr_buf) bfr_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      bfr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      bfr_q <= bfr_d;
    end
  end

  assign cnt = cnt_q;
  assign cap = cap_q;
  assign bfr = bfr_q;

  a_r6_lower_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data));
  a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !cnt_dn && !wr_cnt) |=> cnt_q == '0);
  a_r2_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && cnt_dn && !wr_cnt) |=> at_top);
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_in |=> (cap_q == $past(cnt_q) && bfr_q == $past(cap_q)));
  a_r5_buf_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_in && wr_buf) |=> bfr_q == $past(cap_q));
endmodule

// File: rtl/ctm_upper.sv
module ctm_upper #(
  parameter int W  = 16,
  parameter int NC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  carry,
  input  logic                  suppress,
  input  logic                  cnt_dn,
  input  logic                  clr,
  input  logic                  capb_match,
  input  logic [NC-1:0]         cap0_en,
  input  logic                  wr_cnt,
  input  logic                  wr_cmpa,
  input  logic                  wr_regb,
  input  logic [NC-1:0]         wr_c0,
  input  logic [W-1:0]          wr_data,
  output logic [W-1:0]          cnt,
  output logic [W-1:0]          cmpa,
  output logic [W-1:0]          regb,
  output logic [NC-1:0][W-1:0]  cap0,
  output logic                  match
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d, cmpa_q, cmpa_d, regb_q, regb_d;
  logic         step;

  assign step  = carry && !suppress;
  assign match = carry && (cnt_q == cmpa_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)    cnt_d = wr_data;
    else if (clr)  cnt_d = '0;
    else if (step) cnt_d = cnt_dn ? cnt_q - ONE : cnt_q + ONE;
  end

  always_comb begin
    cmpa_d = cmpa_q;
    regb_d = regb_q;
    if (wr_cmpa) cmpa_d = wr_data;
    if (match && capb_match) regb_d = cnt_q;
    else if (wr_regb)        regb_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmpa_q <= '0;
      regb_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cmpa_q <= cmpa_d;
      regb_q <= regb_d;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_cap0
    logic [W-1:0] c_q, c_d;
    always_comb begin
      c_d = c_q;
      if (carry && cap0_en[i]) c_d = cnt_q;
      else if (wr_c0[i])       c_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end
    assign cap0[i] = c_q;

    a_r8_event_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && cap0_en[i]) |=> c_q == $past(cnt_q));
  end

  assign cnt  = cnt_q;
  assign cmpa = cmpa_q;
  assign regb = regb_q;

  a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && suppress && !wr_cnt) |=> $stable(cnt_q));
  a_r3_upper_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_dn && !wr_cnt) |=> cnt_q == $past(cnt_q) + ONE);
  a_r9_regb_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (match && capb_match) |=> regb_q == $past(cnt_q));
  a_r12_upper_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data));
endmodule

// File: rtl/casc_timer.sv
module casc_timer
  import ctm_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_t1,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          cnt_en,
  input  logic          cnt_dn,
  input  logic          cap_in,
  output logic          lo_carry,
  output logic          up_match,
  output logic          cnt_clear
);
  localparam int NC = N_CAP0;

  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;

  ctm_wport #(.AW(AW), .DW(W)) u_wport (
    .clk(clk), .rst_n(rst_sn), .t1(bus_t1), .addr_in(bus_addr),
    .wdata_in(bus_wdata), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic          wr_lcnt, wr_ucnt, wr_lcmp, wr_ucmpa, wr_uregb;
  logic          wr_lcap, wr_lbuf, wr_ctrl;
  logic [NC-1:0] wr_c0;

  assign wr_lcnt  = wr_en && (wr_addr == AW'(A_LCNT));
  assign wr_ucnt  = wr_en && (wr_addr == AW'(A_UCNT));
  assign wr_lcmp  = wr_en && (wr_addr == AW'(A_LCMP));
  assign wr_ucmpa = wr_en && (wr_addr == AW'(A_UCMPA));
  assign wr_uregb = wr_en && (wr_addr == AW'(A_UREGB));
  assign wr_lcap  = wr_en && (wr_addr == AW'(A_LCAP));
  assign wr_lbuf  = wr_en && (wr_addr == AW'(A_LBUF));
  assign wr_ctrl  = wr_en && (wr_addr == AW'(A_CTRL));

  for (genvar i = 0; i < NC; i++) begin : g_dec
    assign wr_c0[i] = wr_en && (wr_addr == AW'(A_C0_BASE + i));
  end

  ctl_t         ctrl_q, ctrl_d;
  logic [W-1:0] lcmp_q, lcmp_d;

  always_comb begin
    ctrl_d = ctrl_q;
    lcmp_d = lcmp_q;
    if (wr_ctrl) ctrl_d = ctl_t'(wr_data[CTLW-1:0]);
    if (wr_lcmp) lcmp_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      lcmp_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      lcmp_q <= lcmp_d;
    end
  end

  logic [W-1:0]         lo_cnt, lo_cap, lo_bfr, up_cnt, up_cmpa, up_regb;
  logic [NC-1:0][W-1:0] up_c0;
  logic                 hit, carry, match;

  assign hit = ctrl_q.clr_en && (lo_cnt == lcmp_q) && (up_cnt == up_cmpa);

  ctm_lower #(.W(W)) u_lower (
    .clk(clk), .rst_n(rst_sn), .cnt_en(cnt_en), .cnt_dn(cnt_dn), .clr(hit),
    .cap_in(cap_in), .wr_cnt(wr_lcnt), .wr_cap(wr_lcap), .wr_buf(wr_lbuf),
    .wr_data(wr_data), .cnt(lo_cnt), .cap(lo_cap), .bfr(lo_bfr), .carry(carry)
  );

  ctm_upper #(.W(W), .NC(NC)) u_upper (
    .clk(clk), .rst_n(rst_sn), .carry(carry), .suppress(wr_lcnt),
    .cnt_dn(cnt_dn), .clr(hit), .capb_match(ctrl_q.capb_match),
    .cap0_en(ctrl_q.cap0_en), .wr_cnt(wr_ucnt), .wr_cmpa(wr_ucmpa),
    .wr_regb(wr_uregb), .wr_c0(wr_c0), .wr_data(wr_data), .cnt(up_cnt),
    .cmpa(up_cmpa), .regb(up_regb), .cap0(up_c0), .match(match)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_LCNT):  rd_data = lo_cnt;
      AW'(A_UCNT):  rd_data = up_cnt;
      AW'(A_LCMP):  rd_data = lcmp_q;
      AW'(A_UCMPA): rd_data = up_cmpa;
      AW'(A_UREGB): rd_data = up_regb;
      AW'(A_LCAP):  rd_data = lo_cap;
      AW'(A_LBUF):  rd_data = lo_bfr;
      AW'(A_CTRL):  rd_data = W'(ctrl_q);
      default: begin
        for (int i = 0; i < NC; i++)
          if (rd_addr == AW'(A_C0_BASE + i)) rd_data = up_c0[i];
      end
    endcase
  end

  assign lo_carry  = carry;
  assign up_match  = match;
  assign cnt_clear = hit;

  a_r10_clear_both: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt_clear && !wr_lcnt && !wr_ucnt) |=> (lo_cnt == '0 && up_cnt == '0));
  a_r10_no_carry_on_clear: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_clear |-> !lo_carry);
  a_r7_match_needs_carry: assert property (@(posedge clk) disable iff (!rst_sn)
    up_match |-> lo_carry);
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_ctrl |=> ctrl_q == $past(ctl_t'(wr_data[CTLW-1:0])));
endmodule

// File: tb/tb_casc_timer.sv
`timescale 1ns/1ps
module tb_casc_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_t1;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;
  logic        cnt_en, cnt_dn, cap_in;
  logic        lo_carry, up_match, cnt_clear;

  always #2.5 clk = ~clk;

  casc_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_t1(bus_t1), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_en(cnt_en), .cnt_dn(cnt_dn), .cap_in(cap_in),
    .lo_carry(lo_carry), .up_match(up_match), .cnt_clear(cnt_clear)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Reference state derived from the requirements
  logic [15:0] m_lo, m_up, m_lcmp, m_ucmpa, m_regb, m_lcap, m_lbuf;
  logic [5:0]  m_ctl;
  logic [15:0] m_c0 [4];
  logic        m_t2;
  logic [3:0]  m_a;
  logic        g_en, g_dn;
  logic        s_match, s_carry, s_clear;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return m_lo;
      4'd1: return m_up;
      4'd2: return m_lcmp;
      4'd3: return m_ucmpa;
      4'd4: return m_regb;
      4'd5: return m_lcap;
      4'd6: return m_lbuf;
      4'd7: return {10'd0, m_ctl};
      4'd8, 4'd9, 4'd10, 4'd11: return m_c0[a-4'd8];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] stepv(input logic [15:0] v, input logic dn);
    return dn ? v - 16'd1 : v + 16'd1;
  endfunction

  task automatic cyc(input logic t1, input logic [3:0] a, input logic [15:0] d, input logic cp);
    logic hit, car, mt;
    logic [3:0] ra;
    logic [15:0] n_lo, n_up, n_lcmp, n_ucmpa, n_regb, n_lcap, n_lbuf;
    logic [5:0]  n_ctl;
    logic [15:0] n_c0 [4];
    bus_t1 = t1; bus_addr = a; bus_wdata = d;
    cnt_en = g_en; cnt_dn = g_dn; cap_in = cp;
    #1;
    hit = m_ctl[0] && (m_lo == m_lcmp) && (m_up == m_ucmpa);
    car = g_en && !hit && (g_dn ? (m_lo == 16'h0000) : (m_lo == 16'hFFFF));
    mt  = car && (m_up == m_ucmpa);
    chk("R2 lo_carry", {15'd0, lo_carry}, {15'd0, car});
    chk("R7 up_match", {15'd0, up_match}, {15'd0, mt});
    chk("R10 cnt_clear", {15'd0, cnt_clear}, {15'd0, hit});
    s_match = up_match; s_carry = lo_carry; s_clear = cnt_clear;
    ra = 4'($urandom % 16);
    rd_addr = ra;
    #0.5;
    chk("R1 readback", rd_data, mread(ra));
    // next state
    n_lo = m_lo; n_up = m_up; n_lcmp = m_lcmp; n_ucmpa = m_ucmpa; n_regb = m_regb;
    n_lcap = m_lcap; n_lbuf = m_lbuf; n_ctl = m_ctl;
    for (int i = 0; i < 4; i++) n_c0[i] = m_c0[i];
    if (m_t2 && m_a == 4'd0) n_lo = d;
    else if (hit) n_lo = 16'h0000;
    else if (g_en) n_lo = stepv(m_lo, g_dn);
    if (m_t2 && m_a == 4'd1) n_up = d;
    else if (hit) n_up = 16'h0000;
    else if (car && !(m_t2 && m_a == 4'd0)) n_up = stepv(m_up, g_dn);
    if (m_t2 && m_a == 4'd2) n_lcmp = d;
    if (m_t2 && m_a == 4'd3) n_ucmpa = d;
    if (m_t2 && m_a == 4'd7) n_ctl = d[5:0];
    if (mt && m_ctl[1]) n_regb = m_up;
    else if (m_t2 && m_a == 4'd4) n_regb = d;
    if (cp) begin
      n_lcap = m_lo; n_lbuf = m_lcap;
    end else begin
      if (m_t2 && m_a == 4'd5) n_lcap = d;
      if (m_t2 && m_a == 4'd6) n_lbuf = d;
    end
    for (int i = 0; i < 4; i++) begin
      if (car && m_ctl[2+i]) n_c0[i] = m_up;
      else if (m_t2 && m_a == 4'(8 + i)) n_c0[i] = d;
    end
    @(posedge clk);
    m_lo = n_lo; m_up = n_up; m_lcmp = n_lcmp; m_ucmpa = n_ucmpa; m_regb = n_regb;
    m_lcap = n_lcap; m_lbuf = n_lbuf; m_ctl = n_ctl;
    for (int i = 0; i < 4; i++) m_c0[i] = n_c0[i];
    m_t2 = t1; m_a = a;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cyc(1'b1, a, 16'h0, 1'b0);
    cyc(1'b0, 4'd0, d, 1'b0);
  endtask

  function automatic logic [15:0] rd(input logic [3:0] a);
    rd_addr = a;
    return 16'h0;
  endfunction

  task automatic peek(input string req, input logic [3:0] a, input logic [15:0] exp);
    rd_addr = a;
    #0.5;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] u0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_t1 = 0; bus_addr = 0; bus_wdata = 0; rd_addr = 0;
    cnt_en = 0; cnt_dn = 0; cap_in = 0; g_en = 0; g_dn = 0;
    m_lo = 0; m_up = 0; m_lcmp = 0; m_ucmpa = 0; m_regb = 0; m_lcap = 0; m_lbuf = 0;
    m_ctl = 0; m_t2 = 0; m_a = 0;
    for (int i = 0; i < 4; i++) m_c0[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    for (int a = 0; a < 16; a++) peek("R11 reset value", 4'(a), 16'h0000);

    // R1: write and read back, unmapped address ignored
    wr(4'd2, 16'hA5C3);
    peek("R1 write lands two cycles after address phase", 4'd2, 16'hA5C3);
    wr(4'd13, 16'hFFFF);
    peek("R1 unmapped reads zero", 4'd13, 16'h0000);

    // R2/R3: overflow steps the upper count
    wr(4'd0, 16'hFFFE); wr(4'd1, 16'h0007);
    g_en = 1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R2 overflow pulse", {15'd0, s_carry}, 16'd1);
    g_en = 0;
    peek("R2 wrapped to zero", 4'd0, 16'h0000);
    peek("R3 upper stepped up", 4'd1, 16'h0008);

    // R2/R3: underflow
    wr(4'd0, 16'h0001); wr(4'd1, 16'h0003);
    g_en = 1; g_dn = 1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R2 underflow pulse", {15'd0, s_carry}, 16'd1);
    g_en = 0;
    peek("R2 wrapped to FFFF", 4'd0, 16'hFFFF);
    peek("R3 upper stepped down", 4'd1, 16'h0002);
    g_dn = 0;

    // R6/R7/R8/R9: lower write collides with overflow
    wr(4'd7, 16'h003E);
    wr(4'd1, 16'h0040); wr(4'd3, 16'h0040);
    wr(4'd0, 16'hFFFD);
    g_en = 1;
    cyc(0, 0, 0, 0);
    cyc(1, 4'd0, 0, 0);
    cyc(0, 0, 16'h1234, 0);
    chk("R7 match in suppressed cycle", {15'd0, s_match}, 16'd1);
    g_en = 0;
    peek("R6 write applied", 4'd0, 16'h1234);
    peek("R6 upper held", 4'd1, 16'h0040);
    peek("R8 capture on suppressed carry", 4'd8, 16'h0040);
    peek("R8 capture on suppressed carry", 4'd11, 16'h0040);
    peek("R9 regb capture on match", 4'd4, 16'h0040);

    // R8: capture beats write to an event-capture register
    wr(4'd0, 16'hFFFE);
    g_en = 1;
    cyc(1, 4'd9, 0, 0);
    cyc(0, 0, 16'hBEEF, 0);
    g_en = 0;
    peek("R8 capture wins over write", 4'd9, 16'h0040);

    // R12: upper write collides with overflow
    wr(4'd7, 16'h0000);
    wr(4'd0, 16'hFFFE);
    g_en = 1;
    cyc(1, 4'd1, 0, 0);
    cyc(0, 0, 16'h0500, 0);
    g_en = 0;
    peek("R12 upper write wins", 4'd1, 16'h0500);

    // R4/R5: buffer write collides with capture
    wr(4'd5, 16'h1111); wr(4'd6, 16'h2222); wr(4'd0, 16'h0ABC);
    cyc(1, 4'd6, 0, 0);
    cyc(0, 0, 16'h9999, 1);
    peek("R5 buffer write dropped", 4'd6, 16'h1111);
    peek("R4 capture loaded", 4'd5, 16'h0ABC);

    // R10: clear on combined compare
    wr(4'd2, 16'h0005); wr(4'd3, 16'h0002); wr(4'd1, 16'h0002); wr(4'd0, 16'h0003);
    wr(4'd7, 16'h0001);
    g_en = 1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R10 clear flagged", {15'd0, s_clear}, 16'd1);
    g_en = 0;
    peek("R10 lower cleared", 4'd0, 16'h0000);
    peek("R10 upper cleared", 4'd1, 16'h0000);
    wr(4'd7, 16'h0000);

    // Random mix, biased toward wraps and collisions
    for (int k = 0; k < 4000; k++) begin
      logic t1r, cpr;
      logic [3:0] ar;
      logic [15:0] dr;
      if ($urandom % 50 == 0) g_dn = ~g_dn;
      g_en = ($urandom % 10) < 8;
      t1r  = ($urandom % 10) < 3;
      ar   = 4'($urandom % 13);
      dr   = 16'($urandom);
      if (!m_t2 && ($urandom % 2)) dr = 16'hFFF8 + 16'($urandom % 16);
      if (m_t2 && m_a == 4'd7) dr = 16'($urandom % 64);
      cpr  = ($urandom % 10) == 0;
      cyc(t1r, ar, dr, cpr);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule